// File: doc/BRIEF.md
# Sync Word Correlator Detector

This block hunts for a configurable synchronisation word in the serial bit stream that a bit synchronizer delivers. Each accepted bit enters a 32-bit history. The newest 16 or 32 bits are compared against the programmed word, and the mismatches are counted. A match is accepted when the count is within the limit of the selected mode. It must also meet two optional qualifiers: a preamble-quality-reached flag and a carrier-sense flag. On acceptance the block pulses `sync_hit`, raises `locked` and stops searching. From then on every eight valid bits are packed, MSB first, into a data byte that is aligned to the word boundary. A `restart` pulse drops the lock and starts the hunt again.

The block also contains a transmit-side serializer. On `tx_start` it loads the same word, as 16 bits or as a doubled 32-bit word. It then presents the word one bit per `tx_shift` strobe, ahead of the payload. Once the word is exhausted, `tx_bit` passes the payload bit through unchanged.

Top module: `syncword_hunter`

## Requirements
- R1: While `rst_n` is low and at the first cycle after it is released, `sync_hit`, `locked`, `rx_byte_vld` and `tx_sync_active` are all 0.
- R2: With `thr_mode` = 2'b01, a match is accepted when the newest 16 valid bits differ from {`word_hi`,`word_lo`} in at most one position. The word is compared MSB first, so bit 7 of `word_hi` is the oldest bit and bit 0 of `word_lo` is the newest bit.
- R3: With `thr_mode` = 2'b10, a match needs all 16 newest bits equal to {`word_hi`,`word_lo`}; a single wrong bit prevents acceptance.
- R4: With `thr_mode` = 2'b11, the newest 32 valid bits are compared against {`word_hi`,`word_lo`,`word_hi`,`word_lo`}, and at most two mismatches are accepted.
- R5: With `thr_mode` = 2'b00 detection is off and `sync_hit` never pulses.
- R6: When `pq_gate_en` is 1, acceptance also needs `pq_reached` = 1. When `cs_gate_en` is 1, acceptance also needs `cs_present` = 1. Both flags are sampled in the cycle that carries the final bit of the word.
- R7: On acceptance, `sync_hit` is 1 for exactly the one cycle after the clock edge that took the final bit. `locked` rises in that same cycle, and no further `sync_hit` appears while `locked` stays high.
- R8: A match is not considered until at least 16 valid bits (32 in mode 2'b11) have been taken since reset or the last `restart`.
- R9: While locked, each group of 8 valid bits forms `rx_byte`, first bit in bit 7. `rx_byte_vld` is 1 for the one cycle after the edge that took the 8th bit. Cycles with `rx_bit_vld` = 0 contribute nothing.
- R10: `restart` = 1 at a clock edge clears `locked` and the byte position. It discards any bit offered in that cycle and restarts the R8 bit count, so the search resumes.
- R11: `tx_start` loads the word: 32 bits (doubled word) when `thr_mode` = 2'b11, 16 bits otherwise. `tx_sync_active` is 1 while word bits remain. `tx_bit` shows the next word bit, MSB first, and advances by one bit on each `tx_shift`. When no word bits remain, `tx_bit` equals `tx_payload_bit`.
- R12: A `tx_start` while word bits remain reloads the full word; it wins over a `tx_shift` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received bit |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| word_hi | input | 8 | Sync word, first-sent byte |
| word_lo | input | 8 | Sync word, second-sent byte |
| thr_mode | input | 2 | 00 off, 01 15/16, 10 16/16, 11 30/32 |
| pq_gate_en | input | 1 | Require preamble quality for acceptance |
| pq_reached | input | 1 | Preamble quality threshold reached |
| cs_gate_en | input | 1 | Require carrier sense for acceptance |
| cs_present | input | 1 | Carrier sense asserted |
| restart | input | 1 | Drop lock and resume searching |
| sync_hit | output | 1 | One-cycle pulse on acceptance |
| locked | output | 1 | Word accepted, byte output running |
| rx_byte | output | 8 | Aligned received byte |
| rx_byte_vld | output | 1 | One-cycle strobe for `rx_byte` |
| tx_start | input | 1 | Begin sending the sync word |
| tx_shift | input | 1 | Advance the transmit bit |
| tx_payload_bit | input | 1 | Payload bit sent once the word is done |
| tx_bit | output | 1 | Bit to transmit |
| tx_sync_active | output | 1 | Sync word bits still pending |

## Verification
The receive path is fed exact words, words with one bit flipped, and doubled words with two or three flips. Together these separate the three thresholds from each other and from an exact compare. The three-flip pattern is arranged so that a window straddling two words also fails, so a match can only come from the intended alignment. An all-zero word with a stream of zeros shows whether the bit count since restart gates acceptance: it tells a reset-cleared history from a real match. Gaps with an inverted idle bit on every other cycle, and a restart that coincides with a valid bit, show whether invalid cycles and discarded bits leak into the history or the byte packing.

// File: rtl/swh_pkg.sv
// Shared types for the sync word hunter.
// Assumes: the threshold select is a 2-bit code driven by software-held configuration.
package swh_pkg;

    // Acceptance rule selected by the 2-bit threshold code
    typedef enum logic [1:0] {
        THR_OFF   = 2'b00,
        THR_15_16 = 2'b01,
        THR_16_16 = 2'b10,
        THR_30_32 = 2'b11
    } thr_mode_e;

    // Receive framing state
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } rx_state_e;

endpackage

// File: rtl/swh_correlator.sv
// Bit history and correlator.
// Shifts every valid bit into a history of twice the word width. It compares the
// history, with the incoming bit included, against the programmed word and reports
// a combinational hit for the current bit when the mismatch count is within the
// limit of the selected mode and enough bits have arrived since the last clear.
// Assumes: bit_vld is already gated off by the caller when a bit must be discarded.
module swh_correlator
    import swh_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int LOOSE_MISS  = 1,
    parameter int DOUBLE_MISS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              fill_clr,
    input  logic [BYTE_W-1:0] word_hi,
    input  logic [BYTE_W-1:0] word_lo,
    input  thr_mode_e         mode,
    output logic              corr_hit
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAT_W  = 2 * WORD_W;
    localparam int CNT_W  = $clog2(PAT_W + 1);
    localparam logic [CNT_W-1:0] FULL_LEN  = CNT_W'(PAT_W);
    localparam logic [CNT_W-1:0] WORD_LEN  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LOOSE_LIM = CNT_W'(LOOSE_MISS);
    localparam logic [CNT_W-1:0] DBL_LIM   = CNT_W'(DOUBLE_MISS);

    logic [PAT_W-1:0] hist_q;
    logic [PAT_W-1:0] hist_nx;
    logic [PAT_W-1:0] target;
    logic [PAT_W-1:0] diff;
    logic [CNT_W-1:0] fill_q;
    logic [CNT_W-1:0] miss_word;
    logic [CNT_W-1:0] miss_pat;
    logic [CNT_W-1:0] need_len;
    logic             fill_ok;
    logic             thr_ok;

    assign hist_nx = {hist_q[PAT_W-2:0], bit_in};
    assign target  = {word_hi, word_lo, word_hi, word_lo};

    // Per-bit difference between candidate history and target pattern
    generate
        for (genvar g = 0; g < PAT_W; g++) begin : g_cmp
            assign diff[g] = hist_nx[g] ^ target[g];
        end
    endgenerate

    // Count mismatches over the newest word and over the whole pattern
    always_comb begin
        miss_word = '0;
        miss_pat  = '0;
        for (int i = 0; i < PAT_W; i++) begin
            if (i < WORD_W) begin
                miss_word = miss_word + CNT_W'(diff[i]);
            end
            miss_pat = miss_pat + CNT_W'(diff[i]);
        end
    end

    // Decide whether the mismatch count meets the selected rule
    always_comb begin
        need_len = (mode == THR_30_32) ? FULL_LEN : WORD_LEN;
        fill_ok  = (fill_q >= (need_len - CNT_W'(1)));
        unique case (mode)
            THR_15_16: thr_ok = (miss_word <= LOOSE_LIM);
            THR_16_16: thr_ok = (miss_word == '0);
            THR_30_32: thr_ok = (miss_pat <= DBL_LIM);
            default:   thr_ok = 1'b0;
        endcase
        corr_hit = bit_vld && fill_ok && thr_ok;
    end

    // History shift register and saturating count of bits since clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            if (bit_vld) begin
                hist_q <= hist_nx;
            end
            if (fill_clr) begin
                fill_q <= '0;
            end else if (bit_vld && (fill_q != FULL_LEN)) begin
                fill_q <= fill_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/swh_deframer.sv
// Lock control and byte packing.
// In search state it accepts a correlator hit that the qualifiers allow. On
// acceptance it pulses sync_hit and enters the locked state. While locked it packs
// every BYTE_W valid bits, MSB first, into a byte with a one-cycle strobe.
// Assumes: corr_hit is only ever high in a cycle that carries a valid bit.
module swh_deframer
    import swh_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              restart,
    input  logic              corr_hit,
    input  logic              qual_ok,
    output logic              sync_hit,
    output logic              locked,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam logic [BIT_CW-1:0] LAST_POS = BIT_CW'(BYTE_W - 1);

    rx_state_e         state_q;
    logic [BIT_CW-1:0] pos_q;
    logic [BYTE_W-1:0] pack_q;
    logic [BYTE_W-1:0] pack_nx;

    assign pack_nx = {pack_q[BYTE_W-2:0], bit_in};
    assign locked  = (state_q == ST_LOCKED);

    // Search/lock state, acceptance pulse, byte packing and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_SEARCH;
            pos_q    <= '0;
            pack_q   <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
            sync_hit <= 1'b0;
        end else begin
            sync_hit <= 1'b0;
            byte_vld <= 1'b0;
            if (restart) begin
                state_q <= ST_SEARCH;
                pos_q   <= '0;
            end else if (state_q == ST_SEARCH) begin
                if (corr_hit && qual_ok) begin
                    state_q  <= ST_LOCKED;
                    sync_hit <= 1'b1;
                    pos_q    <= '0;
                end
            end else if (bit_vld) begin
                pack_q <= pack_nx;
                if (pos_q == LAST_POS) begin
                    byte_out <= pack_nx;
                    byte_vld <= 1'b1;
                    pos_q    <= '0;
                end else begin
                    pos_q <= pos_q + BIT_CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/swh_serializer.sv
// Transmit-side sync word inserter.
// On start it loads the word, doubled when the 30/32 mode is selected. It presents
// the oldest pending bit and drops it on each shift strobe. When no bits are left,
// the payload bit passes straight through.
// Assumes: start and shift are single-cycle strobes from the transmit sequencer.
module swh_serializer
    import swh_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift,
    input  logic [BYTE_W-1:0] word_hi,
    input  logic [BYTE_W-1:0] word_lo,
    input  thr_mode_e         mode,
    input  logic              payload_bit,
    output logic              tx_bit,
    output logic              active
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAT_W  = 2 * WORD_W;
    localparam int CNT_W  = $clog2(PAT_W + 1);

    logic [PAT_W-1:0] out_q;
    logic [CNT_W-1:0] left_q;
    logic [PAT_W-1:0] load_val;
    logic [CNT_W-1:0] load_len;

    // Choose single or doubled word for loading
    always_comb begin
        if (mode == THR_30_32) begin
            load_val = {word_hi, word_lo, word_hi, word_lo};
            load_len = CNT_W'(PAT_W);
        end else begin
            load_val = {word_hi, word_lo, {WORD_W{1'b0}}};
            load_len = CNT_W'(WORD_W);
        end
    end

    assign active = (left_q != '0);
    assign tx_bit = active ? out_q[PAT_W-1] : payload_bit;

    // Load on start, otherwise drop one pending bit per shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            left_q <= '0;
        end else if (start) begin
            out_q  <= load_val;
            left_q <= load_len;
        end else if (shift && active) begin
            out_q  <= {out_q[PAT_W-2:0], 1'b0};
            left_q <= left_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/syncword_hunter.sv
// Sync word correlator detector, top level.
// Ties the correlator, the lock/byte deframer and the transmit serializer together
// and forms the acceptance qualifier from the preamble-quality and carrier flags.
// Assumes: configuration inputs change only while the receive path is idle or
// about to be restarted; restart discards any bit offered with it.
module syncword_hunter
    import swh_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int LOOSE_MISS  = 1,
    parameter int DOUBLE_MISS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_vld,
    input  logic [BYTE_W-1:0] word_hi,
    input  logic [BYTE_W-1:0] word_lo,
    input  logic [1:0]        thr_mode,
    input  logic              pq_gate_en,
    input  logic              pq_reached,
    input  logic              cs_gate_en,
    input  logic              cs_present,
    input  logic              restart,
    output logic              sync_hit,
    output logic              locked,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_byte_vld,
    input  logic              tx_start,
    input  logic              tx_shift,
    input  logic              tx_payload_bit,
    output logic              tx_bit,
    output logic              tx_sync_active
);
    thr_mode_e mode;
    logic      bit_take;
    logic      corr_hit;
    logic      qual_ok;

    assign mode     = thr_mode_e'(thr_mode);
    assign bit_take = rx_bit_vld && !restart;
    assign qual_ok  = (!pq_gate_en || pq_reached) && (!cs_gate_en || cs_present);

    swh_correlator #(
        .BYTE_W      (BYTE_W),
        .LOOSE_MISS  (LOOSE_MISS),
        .DOUBLE_MISS (DOUBLE_MISS)
    ) corr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .bit_vld  (bit_take),
        .fill_clr (restart),
        .word_hi  (word_hi),
        .word_lo  (word_lo),
        .mode     (mode),
        .corr_hit (corr_hit)
    );

    swh_deframer #(
        .BYTE_W (BYTE_W)
    ) defr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .bit_vld  (bit_take),
        .restart  (restart),
        .corr_hit (corr_hit),
        .qual_ok  (qual_ok),
        .sync_hit (sync_hit),
        .locked   (locked),
        .byte_out (rx_byte),
        .byte_vld (rx_byte_vld)
    );

    swh_serializer #(
        .BYTE_W (BYTE_W)
    ) ser_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (tx_start),
        .shift       (tx_shift),
        .word_hi     (word_hi),
        .word_lo     (word_lo),
        .mode        (mode),
        .payload_bit (tx_payload_bit),
        .tx_bit      (tx_bit),
        .active      (tx_sync_active)
    );

endmodule

// File: rtl/swh_checker.sv
// Temporal checks on the sync word hunter ports, attached by bind.
// Assumes: reset is held low for at least one clock at start-up.
module swh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] thr_mode,
    input logic       restart,
    input logic       sync_hit,
    input logic       locked,
    input logic       rx_byte_vld,
    input logic       tx_start,
    input logic       tx_sync_active
);
    // R7
    sync_pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |=> !sync_hit);

    // R7
    sync_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_hit |-> locked);

    // R7
    lock_rise_with_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> sync_hit);

    // R7
    no_hit_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !restart) |=> !sync_hit);

    // R5
    mode_off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_mode == 2'b00) |=> !sync_hit);

    // R10
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!locked && !rx_byte_vld && !sync_hit));

    // R9
    byte_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_vld |-> $past(locked));

    // R11
    tx_start_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> tx_sync_active);

endmodule

bind syncword_hunter swh_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .thr_mode       (thr_mode),
    .restart        (restart),
    .sync_hit       (sync_hit),
    .locked         (locked),
    .rx_byte_vld    (rx_byte_vld),
    .tx_start       (tx_start),
    .tx_sync_active (tx_sync_active)
);

// File: tb/syncword_hunter_tb.sv
// Bench for the sync word hunter: a behavioural reference model (queues, integers)
// is stepped at every rising edge and compared with the outputs 5 ns later.
module syncword_hunter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic [7:0] word_hi = 8'hA5;
    logic [7:0] word_lo = 8'h3C;
    logic [1:0] thr_mode = 2'b10;
    logic       pq_gate_en = 1'b0;
    logic       pq_reached = 1'b0;
    logic       cs_gate_en = 1'b0;
    logic       cs_present = 1'b0;
    logic       restart = 1'b0;
    logic       sync_hit;
    logic       locked;
    logic [7:0] rx_byte;
    logic       rx_byte_vld;
    logic       tx_start = 1'b0;
    logic       tx_shift = 1'b0;
    logic       tx_payload_bit = 1'b0;
    logic       tx_bit;
    logic       tx_sync_active;

    syncword_hunter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_bit         (rx_bit),
        .rx_bit_vld     (rx_bit_vld),
        .word_hi        (word_hi),
        .word_lo        (word_lo),
        .thr_mode       (thr_mode),
        .pq_gate_en     (pq_gate_en),
        .pq_reached     (pq_reached),
        .cs_gate_en     (cs_gate_en),
        .cs_present     (cs_present),
        .restart        (restart),
        .sync_hit       (sync_hit),
        .locked         (locked),
        .rx_byte        (rx_byte),
        .rx_byte_vld    (rx_byte_vld),
        .tx_start       (tx_start),
        .tx_shift       (tx_shift),
        .tx_payload_bit (tx_payload_bit),
        .tx_bit         (tx_bit),
        .tx_sync_active (tx_sync_active)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_hits   = 0;
    string cur_req  = "R1";
    logic [7:0] last_byte = 8'h00;
    bit    done = 1'b0;

    // reference model state
    bit   hist[$];
    int   m_fill = 0;
    bit   m_locked = 0;
    bit   m_hit = 0;
    bit   m_bvld = 0;
    logic [7:0] m_byte = 8'h00;
    logic [7:0] m_pack = 8'h00;
    int   m_pos = 0;
    bit   txq[$];

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int mismatches(input int need);
        logic [31:0] pat;
        int miss;
        pat  = {word_hi, word_lo, word_hi, word_lo};
        miss = 0;
        for (int i = 0; i < need; i++) begin
            if (hist[hist.size() - 1 - i] != pat[i]) miss++;
        end
        return miss;
    endfunction

    task automatic model_step();
        int need;
        int lim;
        bit qual;
        m_hit  = 0;
        m_bvld = 0;
        if (!rst_n) begin
            hist.delete();
            txq.delete();
            m_fill = 0; m_locked = 0; m_pos = 0; m_pack = 0; m_byte = 0;
            return;
        end
        need = (thr_mode == 2'b11) ? 32 : 16;
        lim  = (thr_mode == 2'b01) ? 1 : (thr_mode == 2'b10) ? 0 : 2;
        qual = (!pq_gate_en || pq_reached) && (!cs_gate_en || cs_present);
        if (restart) begin
            m_locked = 0; m_fill = 0; m_pos = 0;
        end else if (rx_bit_vld) begin
            hist.push_back(rx_bit);
            if (hist.size() > 32) void'(hist.pop_front());
            if (m_fill < 32) m_fill++;
            if (!m_locked) begin
                if (thr_mode != 2'b00 && m_fill >= need && qual && mismatches(need) <= lim) begin
                    m_hit = 1; m_locked = 1; m_pos = 0;
                end
            end else begin
                m_pack = {m_pack[6:0], rx_bit};
                m_pos++;
                if (m_pos == 8) begin
                    m_bvld = 1; m_byte = m_pack; m_pos = 0;
                end
            end
        end
        if (tx_start) begin
            logic [31:0] w;
            int len;
            w   = {word_hi, word_lo, word_hi, word_lo};
            len = (thr_mode == 2'b11) ? 32 : 16;
            txq.delete();
            for (int i = 31; i >= 32 - len; i--) txq.push_back(w[i]);
        end else if (tx_shift && txq.size() > 0) begin
            void'(txq.pop_front());
        end
    endtask

    // Step the model at each edge, compare outputs 5 ns later
    always @(posedge clk) begin
        model_step();
        #5;
        if (rst_n && !done) begin
            chk(cur_req, "sync_hit", sync_hit, m_hit);
            chk(cur_req, "locked", locked, m_locked);
            chk(cur_req, "rx_byte_vld", rx_byte_vld, m_bvld);
            if (m_bvld) chk("R9", "rx_byte", rx_byte, m_byte);
            chk("R11", "tx_sync_active", tx_sync_active, txq.size() > 0);
            chk("R11", "tx_bit", tx_bit, (txq.size() > 0) ? txq[0] : tx_payload_bit);
            if (sync_hit) n_hits++;
            if (rx_byte_vld) last_byte = rx_byte;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic send_bits(input logic [31:0] v, input int n, input bit gaps);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); rx_bit = v[i]; rx_bit_vld = 1'b1;
            if (gaps) begin
                @(negedge clk); rx_bit_vld = 1'b0; rx_bit = ~v[i];
            end
        end
        @(negedge clk); rx_bit_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    task automatic tx_shifts(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_shift = 1'b1;
            @(negedge clk); tx_shift = 1'b0;
        end
    endtask

    initial begin
        int hits0;
        repeat (4) @(negedge clk);
        chk("R1", "locked in reset", locked, 0);
        chk("R1", "sync_hit in reset", sync_hit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "locked after reset", locked, 0);
        chk("R1", "rx_byte_vld after reset", rx_byte_vld, 0);
        chk("R1", "tx_sync_active after reset", tx_sync_active, 0);

        // exact mode, with gaps and noise first
        cur_req = "R3";
        send_bits(32'hFFFF, 16, 1'b1);
        chk("R3", "no lock on noise", locked, 0);
        send_bits(32'hA53C, 16, 1'b1);
        chk("R3", "lock on exact word", locked, 1);
        cur_req = "R9";
        send_bits(32'hC35A, 16, 1'b0);
        chk("R9", "second byte", last_byte, 8'h5A);
        send_bits(32'h81, 8, 1'b1);
        chk("R9", "gapped byte", last_byte, 8'h81);

        // exact mode rejects one flipped bit
        cur_req = "R3";
        do_restart();
        send_bits(32'hA53C ^ 32'h0080, 16, 1'b1);
        chk("R3", "no lock with one flip", locked, 0);

        // loose mode accepts one flipped bit
        cur_req = "R2";
        thr_mode = 2'b01;
        do_restart();
        send_bits(32'hA53C ^ 32'h0080, 16, 1'b1);
        chk("R2", "lock with one flip", locked, 1);
        send_bits(32'h7E, 8, 1'b0);
        chk("R2", "byte after loose lock", last_byte, 8'h7E);

        // doubled word, three then two flips
        cur_req = "R4";
        thr_mode = 2'b11;
        do_restart();
        send_bits(32'hA53CA53C ^ 32'h80008008, 32, 1'b0);
        chk("R4", "no lock with three flips", locked, 0);
        send_bits(32'hA53CA53C ^ 32'h80100000, 32, 1'b0);
        chk("R4", "lock with two flips", locked, 1);

        // detection off
        cur_req = "R5";
        thr_mode = 2'b00;
        do_restart();
        hits0 = n_hits;
        send_bits(32'hA53CA53C, 32, 1'b1);
        chk("R5", "no lock with mode off", locked, 0);
        chk("R5", "no sync pulses", n_hits, hits0);

        // qualifiers
        cur_req = "R6";
        thr_mode = 2'b10;
        pq_gate_en = 1'b1; pq_reached = 1'b0;
        do_restart();
        send_bits(32'hA53C, 16, 1'b1);
        chk("R6", "blocked by preamble quality", locked, 0);
        pq_reached = 1'b1;
        send_bits(32'hA53C, 16, 1'b1);
        chk("R6", "accepted with preamble quality", locked, 1);
        cs_gate_en = 1'b1; cs_present = 1'b0;
        do_restart();
        send_bits(32'hA53C, 16, 1'b0);
        chk("R6", "blocked by carrier sense", locked, 0);
        cs_present = 1'b1;
        send_bits(32'hA53C, 16, 1'b0);
        chk("R6", "accepted with carrier sense", locked, 1);
        pq_gate_en = 1'b0; cs_gate_en = 1'b0;

        // fill count with an all-zero word
        cur_req = "R8";
        word_hi = 8'h00; word_lo = 8'h00;
        do_restart();
        send_bits(32'h0, 15, 1'b0);
        chk("R8", "no lock before 16 bits", locked, 0);
        send_bits(32'h0, 1, 1'b0);
        chk("R8", "lock at 16th bit", locked, 1);
        word_hi = 8'hA5; word_lo = 8'h3C;

        // restart with a coincident bit, then realign
        cur_req = "R10";
        send_bits(32'h5, 3, 1'b0);
        @(negedge clk); restart = 1'b1; rx_bit = 1'b1; rx_bit_vld = 1'b1;
        @(negedge clk); restart = 1'b0; rx_bit_vld = 1'b0;
        chk("R10", "unlocked after restart", locked, 0);
        send_bits(32'hA53C, 16, 1'b1);
        chk("R10", "relock after restart", locked, 1);
        send_bits(32'h96, 8, 1'b1);
        chk("R10", "byte realigned after restart", last_byte, 8'h96);

        // transmit serializer
        cur_req = "R11";
        thr_mode = 2'b01;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        chk("R11", "first tx bit", tx_bit, 1);
        tx_shifts(15);
        chk("R11", "last tx bit", tx_bit, 0);
        chk("R11", "active before last shift", tx_sync_active, 1);
        tx_shifts(1);
        chk("R11", "inactive after 16 shifts", tx_sync_active, 0);
        tx_payload_bit = 1'b1; #1;
        chk("R11", "payload passthrough", tx_bit, 1);
        tx_payload_bit = 1'b0;
        thr_mode = 2'b11;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        tx_shifts(31);
        chk("R11", "doubled word still active", tx_sync_active, 1);
        tx_shifts(1);
        chk("R11", "doubled word done", tx_sync_active, 0);

        // reload while active, start beats shift
        cur_req = "R12";
        thr_mode = 2'b10;
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
        tx_shifts(5);
        @(negedge clk); tx_start = 1'b1; tx_shift = 1'b1;
        @(negedge clk); tx_start = 1'b0; tx_shift = 1'b0;
        chk("R12", "reload restarts at first bit", tx_bit, 1);
        tx_shifts(15);
        chk("R12", "full word after reload", tx_sync_active, 1);
        tx_shifts(1);
        chk("R12", "reload word done", tx_sync_active, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule